// File: doc/BRIEF.md
# Speculation-Labelled Cache Tag Array

This block holds the tag and state array of a small set-associative cache. Every way keeps speculatively installed lines apart from committed lines without moving any data. Each way carries a valid bit, a tag, a domain label (temporary or persistent) and the identifier of the in-flight load that installed it. A fill made by a speculative load lands in the temporary domain. When that load's speculation is confirmed, a commit request turns its lines persistent by clearing the label bit. When the speculation is rejected, a squash request invalidates those lines. No way is reserved for either domain: the split of each set changes as labels change.

Requests come in on one lookup/fill port, which carries a speculative flag and an identifier. The response is registered and appears one cycle later as hit, miss, filled or refused, together with the way. A speculative fill never displaces a persistent line. When no invalid or temporary way is free it is refused, and the requester retries once its load is no longer speculative. Commit and squash requests each act on every way of every set in one cycle. Data storage and refill traffic are handled outside this block.

The response state register has five named states: `RSP_IDLE`, `RSP_HIT`, `RSP_MISS`, `RSP_FILL` and `RSP_REFUSE`. The transition taken on each clock is chosen by the request sampled at that edge:
- no request goes to `RSP_IDLE`;
- a visible tag match goes to `RSP_HIT`;
- a lookup without a match goes to `RSP_MISS`;
- a fill that found a way goes to `RSP_FILL`;
- a speculative fill with no legal way goes to `RSP_REFUSE`.

Top module: `specset_array`

## Requirements
- R1: After reset every way is invalid and `resp_valid` is low, so every lookup in every set misses.
- R2: A request accepted at a clock edge is answered at the next edge. `resp_valid` is high for exactly one cycle, `resp_hit` reports a visible tag match and `resp_way` gives the matching or installed way. The lowest-numbered way wins when more than one way matches.
- R3: A speculative fill installs its line with the temporary label and the request identifier. A temporary line is visible only to speculative requests that carry the same identifier. Non-speculative requests, and speculative requests with another identifier, miss on it.
- R4: A speculative fill without a visible match takes the lowest invalid way, otherwise the lowest temporary way. It never takes a persistent way. When every way is persistent, the fill answers with `resp_refused` high and `resp_hit` low, and the set is left unchanged.
- R5: A commit request marks every temporary line with the given identifier persistent, in the same way and with the same tag. From then on it is visible to all requests.
- R6: A squash request invalidates every temporary line with the given identifier. Lines with other identifiers and persistent lines are unchanged.
- R7: When a commit and a squash name the same identifier in the same cycle, the squash wins and the lines are invalidated.
- R8: A non-speculative fill without a visible match installs a persistent line in the lowest invalid way. If there is none, it takes the pseudo-LRU victim, and this victim may be any way. Such a fill is never refused.
- R9: The pseudo-LRU state of each set is a binary tree of WAYS-1 node bits. Nodes are numbered from 1 at the root, and node n has children 2n and 2n+1. The victim is found by walking from the root, going to the lower half when the bit is 0 and to the upper half when it is 1. The tree is updated by a non-speculative hit on a persistent line or by a non-speculative fill: each node on that way's path is set to point away from it. Speculative requests, commits and squashes never change the tree. Reset clears all node bits.
- R10: A fill that finds a visible match reports a hit on that way and installs nothing.
- R11: Commit and squash act on all sets in the cycle they are requested. They act on the lines present before that cycle, and a fill in the same cycle writes its own way after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup or fill request present |
| req_fill | input | 1 | 1: fill on miss, 0: lookup only |
| req_spec | input | 1 | Request issued by a speculative load |
| req_id | input | ID_W | Speculation identifier of the request |
| req_set | input | log2(SETS) | Set index |
| req_tag | input | TAG_W | Tag compared and installed |
| commit_valid | input | 1 | Commit the lines of `commit_id` |
| commit_id | input | ID_W | Identifier to commit |
| squash_valid | input | 1 | Squash the lines of `squash_id` |
| squash_id | input | ID_W | Identifier to squash |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | Visible match found |
| resp_refused | output | 1 | Speculative fill refused |
| resp_way | output | log2(WAYS) | Way hit or installed |

## Verification
The properties assume that commit and squash requests only name lines while no lookup or fill is issued in that cycle. A fill writing a line in the same cycle would otherwise mask the label flip or the invalidation they check. The bench keeps to this by giving maintenance requests cycles of their own. It then sweeps a four-set, four-way configuration over a narrow tag range so that fills collide, and compares every response with an arithmetic model of labels, identifiers and the tree bits.

// File: rtl/specset_pkg.sv
package specset_pkg;
    typedef enum logic [2:0] {
        RSP_IDLE,
        RSP_HIT,
        RSP_MISS,
        RSP_FILL,
        RSP_REFUSE
    } rsp_state_e;
endpackage

// File: rtl/specset_match.sv
module specset_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int ID_W  = 4
) (
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0]             tmp,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [WAYS-1:0][ID_W-1:0]   ids,
    input  logic [TAG_W-1:0]            req_tag,
    input  logic                        req_spec,
    input  logic [ID_W-1:0]             req_id,
    output logic                        hit,
    output logic [$clog2(WAYS)-1:0]     hit_way,
    output logic                        hit_persist
);
    localparam int LVL = $clog2(WAYS);

    logic [WAYS-1:0] seen;

    // a temporary line is visible only to its own speculative load
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign seen[w] = vld[w] && (tags[w] == req_tag) &&
                         (!tmp[w] || (req_spec && (ids[w] == req_id)));
    end

    always_comb begin
        hit         = |seen;
        hit_way     = '0;
        hit_persist = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (seen[w]) begin
                hit_way     = LVL'(w);
                hit_persist = !tmp[w];
            end
        end
    end
endmodule

// File: rtl/specset_victim.sv
module specset_victim #(
    parameter int WAYS = 4
) (
    input  logic                    spec,
    input  logic [WAYS-1:0]         vld,
    input  logic [WAYS-1:0]         tmp,
    input  logic [WAYS-1:1]         plru,
    output logic                    ok,
    output logic [$clog2(WAYS)-1:0] way
);
    localparam int LVL = $clog2(WAYS);

    logic           inv_f, tmp_f;
    logic [LVL-1:0] inv_w, tmp_w, tree_w;

    always_comb begin
        inv_f = 1'b0;
        tmp_f = 1'b0;
        inv_w = '0;
        tmp_w = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) begin
                inv_f = 1'b1;
                inv_w = LVL'(w);
            end
            if (vld[w] && tmp[w]) begin
                tmp_f = 1'b1;
                tmp_w = LVL'(w);
            end
        end
    end

    always_comb begin
        int n;
        n      = 1;
        tree_w = '0;
        for (int l = 0; l < LVL; l++) begin
            tree_w[LVL-1-l] = plru[n];
            n = 2 * n + int'(plru[n]);
        end
    end

    // speculative fills may only reuse invalid or temporary ways
    assign ok  = inv_f || !spec || tmp_f;
    assign way = inv_f ? inv_w : (spec ? tmp_w : tree_w);
endmodule

// File: rtl/specset_plru.sv
module specset_plru #(
    parameter int WAYS = 4
) (
    input  logic [WAYS-1:1]         cur,
    input  logic [$clog2(WAYS)-1:0] way,
    output logic [WAYS-1:1]         nxt
);
    localparam int LVL = $clog2(WAYS);

    always_comb begin
        int n;
        nxt = cur;
        n   = 1;
        for (int l = 0; l < LVL; l++) begin
            nxt[n] = !way[LVL-1-l];
            n = 2 * n + int'(way[LVL-1-l]);
        end
    end
endmodule

// File: rtl/specset_array.sv
module specset_array
    import specset_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int ID_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_fill,
    input  logic                    req_spec,
    input  logic [ID_W-1:0]         req_id,
    input  logic [$clog2(SETS)-1:0] req_set,
    input  logic [TAG_W-1:0]        req_tag,
    input  logic                    commit_valid,
    input  logic [ID_W-1:0]         commit_id,
    input  logic                    squash_valid,
    input  logic [ID_W-1:0]         squash_id,
    output logic                    resp_valid,
    output logic                    resp_hit,
    output logic                    resp_refused,
    output logic [$clog2(WAYS)-1:0] resp_way
);
    localparam int LVL = $clog2(WAYS);

    logic [SETS-1:0][WAYS-1:0]             vld_q, vld_d;
    logic [SETS-1:0][WAYS-1:0]             tmp_q, tmp_d;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q, tag_d;
    logic [SETS-1:0][WAYS-1:0][ID_W-1:0]   id_q, id_d;
    logic [SETS-1:0][WAYS-1:1]             plru_q, plru_d;

    rsp_state_e     rsp_q, rsp_d;
    logic [LVL-1:0] way_q, way_d;

    logic           hit, hit_persist, vict_ok;
    logic [LVL-1:0] hit_way, vict_way, touch_way;
    logic [WAYS-1:1] plru_new;

    specset_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ID_W(ID_W)) i_match (
        .vld         (vld_q[req_set]),
        .tmp         (tmp_q[req_set]),
        .tags        (tag_q[req_set]),
        .ids         (id_q[req_set]),
        .req_tag     (req_tag),
        .req_spec    (req_spec),
        .req_id      (req_id),
        .hit         (hit),
        .hit_way     (hit_way),
        .hit_persist (hit_persist)
    );

    specset_victim #(.WAYS(WAYS)) i_victim (
        .spec (req_spec),
        .vld  (vld_q[req_set]),
        .tmp  (tmp_q[req_set]),
        .plru (plru_q[req_set]),
        .ok   (vict_ok),
        .way  (vict_way)
    );

    assign touch_way = hit ? hit_way : vict_way;

    specset_plru #(.WAYS(WAYS)) i_plru (
        .cur (plru_q[req_set]),
        .way (touch_way),
        .nxt (plru_new)
    );

    // next array contents and next response state
    always_comb begin
        vld_d  = vld_q;
        tmp_d  = tmp_q;
        tag_d  = tag_q;
        id_d   = id_q;
        plru_d = plru_q;
        rsp_d  = RSP_IDLE;
        way_d  = way_q;

        // maintenance over every way of every set, squash first
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                if (vld_q[s][w] && tmp_q[s][w]) begin
                    if (squash_valid && (id_q[s][w] == squash_id))
                        vld_d[s][w] = 1'b0;
                    else if (commit_valid && (id_q[s][w] == commit_id))
                        tmp_d[s][w] = 1'b0;
                end
            end
        end

        if (req_valid) begin
            if (hit) begin
                rsp_d = RSP_HIT;
                way_d = hit_way;
                if (hit_persist && !req_spec)
                    plru_d[req_set] = plru_new;
            end else if (!req_fill) begin
                rsp_d = RSP_MISS;
            end else if (!vict_ok) begin
                rsp_d = RSP_REFUSE;
            end else begin
                rsp_d = RSP_FILL;
                way_d = vict_way;
                vld_d[req_set][vict_way] = 1'b1;
                tmp_d[req_set][vict_way] = req_spec;
                tag_d[req_set][vict_way] = req_tag;
                id_d[req_set][vict_way]  = req_id;
                if (!req_spec)
                    plru_d[req_set] = plru_new;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q  <= RSP_IDLE;
            way_q  <= '0;
            vld_q  <= '0;
            tmp_q  <= '0;
            tag_q  <= '0;
            id_q   <= '0;
            plru_q <= '0;
        end else begin
            rsp_q  <= rsp_d;
            way_q  <= way_d;
            vld_q  <= vld_d;
            tmp_q  <= tmp_d;
            tag_q  <= tag_d;
            id_q   <= id_d;
            plru_q <= plru_d;
        end
    end

    // outputs decoded from the response state
    always_comb begin
        resp_valid   = 1'b1;
        resp_hit     = 1'b0;
        resp_refused = 1'b0;
        resp_way     = way_q;
        unique case (rsp_q)
            RSP_IDLE: begin
                resp_valid = 1'b0;
                resp_way   = '0;
            end
            RSP_HIT:    resp_hit = 1'b1;
            RSP_MISS:   resp_way = '0;
            RSP_FILL:   resp_hit = 1'b0;
            RSP_REFUSE: begin
                resp_refused = 1'b1;
                resp_way     = '0;
            end
            default:    resp_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/specset_checker.sv
module specset_checker #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int ID_W  = 4
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 req_valid,
    input logic                                 req_fill,
    input logic                                 req_spec,
    input logic                                 commit_valid,
    input logic [ID_W-1:0]                      commit_id,
    input logic                                 squash_valid,
    input logic [ID_W-1:0]                      squash_id,
    input logic                                 resp_valid,
    input logic                                 resp_hit,
    input logic                                 resp_refused,
    input logic [SETS-1:0][WAYS-1:0]            vld,
    input logic [SETS-1:0][WAYS-1:0]            tmp,
    input logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag,
    input logic [SETS-1:0][WAYS-1:0][ID_W-1:0]  id,
    input logic [SETS-1:0][WAYS-1:1]            plru
);
    AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid); // R2
    AST_RESP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid); // R2
    AST_REFUSE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        resp_refused |-> (resp_valid && !resp_hit)); // R4
    AST_NONSPEC_NEVER_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fill && !req_spec) |=> !resp_refused); // R8
    AST_SPEC_NO_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_spec) |=> $stable(plru)); // R9

    for (genvar s = 0; s < SETS; s++) begin : g_set
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            AST_PERSIST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
                (vld[s][w] && !tmp[s][w] && !(req_valid && req_fill && !req_spec))
                |=> (vld[s][w] && !tmp[s][w] && $stable(tag[s][w]))); // R4
            AST_SQUASH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
                (squash_valid && !req_valid && vld[s][w] && tmp[s][w] &&
                 id[s][w] == squash_id) |=> !vld[s][w]); // R6
            AST_COMMIT_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
                (commit_valid && !(squash_valid && squash_id == commit_id) &&
                 !req_valid && vld[s][w] && tmp[s][w] && id[s][w] == commit_id)
                |=> (vld[s][w] && !tmp[s][w] && $stable(tag[s][w]))); // R5
            AST_SQUASH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                (commit_valid && squash_valid && commit_id == squash_id &&
                 !req_valid && vld[s][w] && tmp[s][w] && id[s][w] == squash_id)
                |=> !vld[s][w]); // R7
        end
    end
endmodule

bind specset_array specset_checker #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .ID_W(ID_W)
) i_specset_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_fill     (req_fill),
    .req_spec     (req_spec),
    .commit_valid (commit_valid),
    .commit_id    (commit_id),
    .squash_valid (squash_valid),
    .squash_id    (squash_id),
    .resp_valid   (resp_valid),
    .resp_hit     (resp_hit),
    .resp_refused (resp_refused),
    .vld          (vld_q),
    .tmp          (tmp_q),
    .tag          (tag_q),
    .id           (id_q),
    .plru         (plru_q)
);

// File: tb/test_specset_array.sv
module test_specset_array;
    localparam int SETS  = 4;
    localparam int WAYS  = 4;
    localparam int TAG_W = 6;
    localparam int ID_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_fill = 1'b0, req_spec = 1'b0;
    logic [ID_W-1:0] req_id = '0;
    logic [1:0] req_set = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic commit_valid = 1'b0, squash_valid = 1'b0;
    logic [ID_W-1:0] commit_id = '0, squash_id = '0;
    logic resp_valid, resp_hit, resp_refused;
    logic [1:0] resp_way;

    int checks = 0;
    int fails  = 0;

    // reference state
    bit m_vld [SETS][WAYS];
    bit m_tmp [SETS][WAYS];
    int m_tag [SETS][WAYS];
    int m_id  [SETS][WAYS];
    bit m_tree[SETS][WAYS];

    always #4 clk = ~clk;

    specset_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .ID_W(ID_W)) i_specset_array (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_fill(req_fill), .req_spec(req_spec),
        .req_id(req_id), .req_set(req_set), .req_tag(req_tag),
        .commit_valid(commit_valid), .commit_id(commit_id),
        .squash_valid(squash_valid), .squash_id(squash_id),
        .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_refused(resp_refused), .resp_way(resp_way)
    );

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic int find_hit(input int s, input int tg, input bit sp, input int id);
        for (int w = 0; w < WAYS; w++)
            if (m_vld[s][w] && m_tag[s][w] == tg && (!m_tmp[s][w] || (sp && m_id[s][w] == id)))
                return w;
        return -1;
    endfunction

    function automatic int tree_victim(input int s);
        int n = 1;
        int v = 0;
        for (int l = 0; l < 2; l++) begin
            v = v * 2 + int'(m_tree[s][n]);
            n = 2 * n + int'(m_tree[s][n]);
        end
        return v;
    endfunction

    function automatic void tree_touch(input int s, input int w);
        int n = 1;
        for (int l = 0; l < 2; l++) begin
            int b = (w >> (1 - l)) & 1;
            m_tree[s][n] = (b == 0);
            n = 2 * n + b;
        end
    endfunction

    function automatic int pick_way(input int s, input bit sp);
        for (int w = 0; w < WAYS; w++) if (!m_vld[s][w]) return w;
        if (sp) begin
            for (int w = 0; w < WAYS; w++) if (m_tmp[s][w]) return w;
            return -1;
        end
        return tree_victim(s);
    endfunction

    // drives one request at a falling edge, checks the answer one cycle later
    task automatic do_req(input bit f, input bit sp, input int id, input int s, input int tg, input string rq);
        int ew, ek, act, exp;
        ew = find_hit(s, tg, sp, id);
        if (ew >= 0) ek = 0;
        else if (!f) ek = 1;
        else begin
            ew = pick_way(s, sp);
            ek = (ew < 0) ? 3 : 2;
        end
        req_valid = 1'b1; req_fill = f; req_spec = sp;
        req_id = ID_W'(id); req_set = 2'(s); req_tag = TAG_W'(tg);
        @(negedge clk);
        req_valid = 1'b0;
        act = {resp_valid, resp_hit, resp_refused, resp_way};
        exp = {1'b1, ek == 0, ek == 3, (ek == 0 || ek == 2) ? 2'(ew) : 2'd0};
        chk(act == exp, rq, $sformatf("set %0d tag %0d spec %0d id %0d fill %0d", s, tg, sp, id, f), act, exp);
        if (ek == 0 && !m_tmp[s][ew] && !sp) tree_touch(s, ew);
        if (ek == 2) begin
            m_vld[s][ew] = 1'b1; m_tmp[s][ew] = sp; m_tag[s][ew] = tg; m_id[s][ew] = id;
            if (!sp) tree_touch(s, ew);
        end
    endtask

    task automatic do_maint(input bit c, input int cid, input bit q, input int qid);
        commit_valid = c; commit_id = ID_W'(cid);
        squash_valid = q; squash_id = ID_W'(qid);
        @(negedge clk);
        commit_valid = 1'b0; squash_valid = 1'b0;
        chk(resp_valid == 1'b0, "R2", "no response without request", int'(resp_valid), 0);
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                if (m_vld[s][w] && m_tmp[s][w]) begin
                    if (q && m_id[s][w] == qid) m_vld[s][w] = 1'b0;
                    else if (c && m_id[s][w] == cid) m_tmp[s][w] = 1'b0;
                end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_vld[s][w] = 0; m_tmp[s][w] = 0; m_tag[s][w] = 0; m_id[s][w] = 0; m_tree[s][w] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(resp_valid == 1'b0, "R1", "resp_valid after reset", int'(resp_valid), 0);
        for (int s = 0; s < SETS; s++) do_req(0, 0, 0, s, 0, "R1");

        // non-speculative fills, lookups, refill of a present tag
        for (int t = 1; t <= 4; t++) do_req(1, 0, 0, 1, t, "R8");
        for (int t = 1; t <= 4; t++) do_req(0, 0, 0, 1, t, "R2");
        do_req(1, 0, 0, 1, 2, "R10");
        do_req(0, 1, 2, 1, 3, "R9");
        do_req(1, 0, 0, 1, 9, "R9");
        do_req(0, 0, 0, 1, 9, "R8");

        // full persistent set refuses speculative fills
        do_req(1, 1, 1, 1, 30, "R4");
        for (int t = 1; t <= 4; t++) do_req(0, 0, 0, 1, t == 1 ? 9 : t, "R4");

        // visibility of a temporary line
        do_req(1, 1, 3, 2, 5, "R3");
        do_req(0, 1, 3, 2, 5, "R3");
        do_req(0, 0, 0, 2, 5, "R3");
        do_req(0, 1, 4, 2, 5, "R3");

        // speculative fill reuses a temporary way, then commit
        for (int t = 10; t <= 12; t++) do_req(1, 0, 0, 2, t, "R8");
        do_req(1, 1, 5, 2, 13, "R4");
        do_maint(1, 5, 0, 0);
        do_req(0, 0, 0, 2, 13, "R5");

        // squash across sets
        do_req(1, 1, 6, 0, 14, "R3");
        do_req(1, 1, 6, 3, 15, "R3");
        do_maint(0, 0, 1, 6);
        do_req(0, 1, 6, 0, 14, "R11");
        do_req(0, 1, 6, 3, 15, "R6");

        // commit and squash of one identifier in one cycle
        do_req(1, 1, 7, 3, 20, "R7");
        do_maint(1, 7, 1, 7);
        do_req(0, 1, 7, 3, 20, "R7");
        do_req(0, 0, 0, 3, 20, "R7");

        // random mix with colliding tags
        for (int i = 0; i < 3000; i++) begin
            int op = $urandom_range(0, 9);
            int s  = $urandom_range(0, SETS - 1);
            int tg = $urandom_range(0, 7);
            int id = $urandom_range(0, 3);
            bit sp = $urandom_range(0, 1);
            if (op < 4) do_req(0, sp, id, s, tg, "R3");
            else if (op < 8) do_req(1, sp, id, s, tg, sp ? "R4" : "R8");
            else if (op == 8) do_maint(1, id, $urandom_range(0, 1), $urandom_range(0, 3));
            else do_maint(0, 0, 1, id);
        end

        // sweep of every visible tag for every view
        for (int s = 0; s < SETS; s++)
            for (int tg = 0; tg < 8; tg++) begin
                do_req(0, 0, 0, s, tg, "R5");
                for (int id = 0; id < 4; id++) do_req(0, 1, id, s, tg, "R6");
            end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule